// File: doc/BRIEF.md
# Wake Event Status Controller

This block gathers wake requests from four sources: two ring-indicate lines, a keyboard and a mouse. Each request is captured in a sticky status bit, and the block drives one active-low power-management-event line. Software reaches the block through a small indexed register bus. A status register holds the captured events and is cleared by writing ones. An enable register chooses which sources may drive the event line. A global enable input, driven by a separate configuration register, gates the whole output.

Status records every event, whatever the enables hold. Only the standby-supply power-on reset clears the block. Main-supply and software resets are not wired to it, so the stored state outlives them. Each wake input is asynchronous and passes through a two-flop synchronizer. The rising edge of the synchronized level is what counts as an event.

Top module: `wake_event_ctrl`

## Requirements
- R1: While `stby_por_n` is low, both registers are 0x00 and `pme_n` is 1. Both remain so after release until an event or a write occurs.
- R2: In both registers, bit 1 belongs to ring indicate 2, bit 2 to ring indicate 1, bit 3 to the keyboard and bit 4 to the mouse. The status register is at index 0xC7 and the enable register is at index 0xC8.
- R3: A rising edge on a wake input sets its status bit three clock edges after the input changes. This happens whatever the enable bits and the global enable hold. The bit is not yet set after two edges.
- R4: A write to the status index clears every status bit in 4:1 whose data bit is 1. Data bits that are 0 leave the matching status bits unchanged.
- R5: If a synchronized rising edge and a clearing write reach the same status bit on the same clock edge, the bit ends up set.
- R6: A write to the enable index stores data bits 4:1. Bits 0 and 7:5 of both registers always read 0, and writes to those bits have no effect.
- R7: `pme_n` is registered. It is 0 exactly one clock after the cycle in which the global enable is 1 and some source has both its status bit and its enable bit at 1. Otherwise it is 1, including one clock after the last such bit is cleared or disabled.
- R8: `reg_rdata` is 0x00 when `reg_rd` is low, and also when the index is neither 0xC7 nor 0xC8.
- R9: A wake input held high sets its status bit only once. After that bit is cleared, it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_por_n | input | 1 | Standby-supply power-on reset, active low, asynchronous |
| ri2_in | input | 1 | Ring indicate 2 wake request (asynchronous) |
| ri1_in | input | 1 | Ring indicate 1 wake request (asynchronous) |
| kbd_in | input | 1 | Keyboard wake request (asynchronous) |
| mouse_in | input | 1 | Mouse wake request (asynchronous) |
| pme_global_en | input | 1 | Global enable for the event output |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_rd | input | 1 | Read strobe, combinational read |
| reg_rdata | output | 8 | Read data |
| pme_n | output | 1 | Power-management event, active low |

## Verification
A change on a wake input shows up in a status read three clock edges later, and `pme_n` follows one edge after that. A register write takes effect on the edge that samples it, and `pme_n` responds to that write one edge later. Reads are combinational and need no clock. The bench drives every input just after a falling edge and samples only in the low half of the clock. For each latency it checks both the last edge before the change, where the old value must still hold, and the edge where the new value must appear. The same-cycle priority case is timed so that the clearing write lands on the third edge after the input rises.

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl #(
  parameter logic [7:0] STS_INDEX = 8'hC7,
  parameter logic [7:0] EN_INDEX  = 8'hC8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       stby_por_n,
  input  logic       ri2_in,
  input  logic       ri1_in,
  input  logic       kbd_in,
  input  logic       mouse_in,
  input  logic       pme_global_en,
  input  logic [7:0] reg_idx,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       pme_n
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] src_raw, rise, sts, en, sts_clr;
  logic [SYNC_STAGES:0][NSRC-1:0] pipe;
  logic sts_wr, en_wr, unused_wdata_bits;

  assign src_raw = {mouse_in, kbd_in, ri1_in, ri2_in};
  assign rise    = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  assign sts_wr  = reg_wr && (reg_idx == STS_INDEX);
  assign en_wr   = reg_wr && (reg_idx == EN_INDEX);
  assign sts_clr = sts_wr ? reg_wdata[NSRC:1] : '0;
  assign unused_wdata_bits = ^{reg_wdata[7:NSRC+1], reg_wdata[0]};

  always_ff @(posedge clk or negedge stby_por_n) begin
    if (!stby_por_n) begin
      pipe  <= '0;
      sts   <= '0;
      en    <= '0;
      pme_n <= 1'b1;
    end else begin
      pipe  <= {pipe[SYNC_STAGES-1:0], src_raw};
      sts   <= (sts & ~sts_clr) | rise;
      if (en_wr) en <= reg_wdata[NSRC:1];
      pme_n <= ~(pme_global_en && |(sts & en));
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      if (reg_idx == STS_INDEX)     reg_rdata = {{(7-NSRC){1'b0}}, sts, 1'b0};
      else if (reg_idx == EN_INDEX) reg_rdata = {{(7-NSRC){1'b0}}, en, 1'b0};
    end
  end

  always_comb begin
    assert_reserved_zero_R6: assert (reg_rdata[0] == 1'b0 && reg_rdata[7:NSRC+1] == '0)
      else $error("reserved read bits nonzero");
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!stby_por_n)
    (rise != '0) |=> ((sts & $past(rise)) == $past(rise)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!stby_por_n)
    sts_wr |=> ((sts & $past(reg_wdata[NSRC:1] & ~rise)) == '0));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!stby_por_n)
    (!sts_wr && rise == '0) |=> $stable(sts));

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!stby_por_n)
    !en_wr |=> $stable(en));

  assert_gen_off_R7: assert property (@(posedge clk) disable iff (!stby_por_n)
    !pme_global_en |=> pme_n);

  assert_no_source_R7: assert property (@(posedge clk) disable iff (!stby_por_n)
    ((sts & en) == '0) |=> pme_n);
endmodule

// File: tb/sim_wake_event_ctrl.sv
module sim_wake_event_ctrl;
  logic clk = 1'b0;
  logic stby_por_n = 1'b0;
  logic [3:0] src = 4'h0;
  logic gen = 1'b0;
  logic [7:0] idx = 8'h00, wdata = 8'h00, rdata, rv;
  logic wr = 1'b0, rd = 1'b0, pme_n;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wake_event_ctrl u0 (
    .clk(clk), .stby_por_n(stby_por_n),
    .ri2_in(src[0]), .ri1_in(src[1]), .kbd_in(src[2]), .mouse_in(src[3]),
    .pme_global_en(gen), .reg_idx(idx), .reg_wdata(wdata),
    .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata), .pme_n(pme_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    idx = i; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    idx = i; rd = 1'b1;
    #2 v = rdata;
    rd = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [7:0] exp_sts;
    step(3);
    chk("R1 pme_n in reset", {7'b0, pme_n}, 8'h01);
    stby_por_n = 1'b1;
    step(2);
    rd_reg(8'hC7, rv); chk("R1 status after reset", rv, 8'h00);
    rd_reg(8'hC8, rv); chk("R1 enable after reset", rv, 8'h00);
    chk("R1 pme_n after reset", {7'b0, pme_n}, 8'h01);

    for (int d = 0; d < 256; d++) begin
      wr_reg(8'hC8, d[7:0]);
      rd_reg(8'hC8, rv);
      chk("R6 enable write/read", rv, d[7:0] & 8'h1E);
    end
    wr_reg(8'hC8, 8'h1E);
    idx = 8'hC8; rd = 1'b0; #2 chk("R8 no strobe reads zero", rdata, 8'h00);
    foreach (rv[k]) begin
      logic [7:0] oi;
      oi = 8'hC6 + 8'(k * 37);
      if (oi != 8'hC7 && oi != 8'hC8) begin
        rd_reg(oi, rv); chk("R8 other index", rv, 8'h00);
      end
    end
    rd_reg(8'hC9, rv); chk("R8 index C9", rv, 8'h00);
    wr_reg(8'hC8, 8'h00);

    exp_sts = 8'h00;
    for (int i = 0; i < 4; i++) begin
      src[i] = 1'b1;
      step(2);
      rd_reg(8'hC7, rv); chk("R3 not set after two edges", rv, exp_sts);
      step(1);
      exp_sts |= 8'(1 << (i + 1));
      rd_reg(8'hC7, rv); chk("R2 R3 bit position", rv, exp_sts);
      src[i] = 1'b0;
      step(1);
      chk("R7 disabled source no event", {7'b0, pme_n}, 8'h01);
    end
    step(3);

    wr_reg(8'hC7, 8'h00);
    rd_reg(8'hC7, rv); chk("R4 write zero no effect", rv, 8'h1E);
    wr_reg(8'hC7, 8'hE1);
    rd_reg(8'hC7, rv); chk("R6 reserved write no effect", rv, 8'h1E);
    for (int i = 1; i <= 4; i++) begin
      wr_reg(8'hC7, 8'(1 << i));
      exp_sts &= ~8'(1 << i);
      rd_reg(8'hC7, rv); chk("R4 clear single bit", rv, exp_sts);
    end

    src[2] = 1'b1;
    step(4);
    rd_reg(8'hC7, rv); chk("R9 held input sets", rv, 8'h08);
    wr_reg(8'hC7, 8'h08);
    step(5);
    rd_reg(8'hC7, rv); chk("R9 held input no reset", rv, 8'h00);
    src[2] = 1'b0;
    step(3);
    src[2] = 1'b1;
    step(4);
    rd_reg(8'hC7, rv); chk("R9 new edge sets", rv, 8'h08);
    src[2] = 1'b0;
    step(3);

    src[2] = 1'b1;
    step(2);
    wr_reg(8'hC7, 8'h08);
    rd_reg(8'hC7, rv); chk("R5 set beats clear", rv, 8'h08);
    src[2] = 1'b0;
    step(3);
    wr_reg(8'hC7, 8'h1E);
    rd_reg(8'hC7, rv); chk("R4 clear all", rv, 8'h00);

    wr_reg(8'hC8, 8'h1E);
    gen = 1'b1;
    src[3] = 1'b1;
    step(3);
    chk("R7 pme not yet", {7'b0, pme_n}, 8'h01);
    step(1);
    chk("R7 pme asserted", {7'b0, pme_n}, 8'h00);
    src[3] = 1'b0;
    wr_reg(8'hC7, 8'h10);
    chk("R7 pme held one clock", {7'b0, pme_n}, 8'h00);
    step(1);
    chk("R7 pme released", {7'b0, pme_n}, 8'h01);

    src = 4'hF;
    step(4);
    src = 4'h0;
    step(3);
    for (int g = 0; g < 2; g++) begin
      gen = g[0];
      for (int e = 0; e < 16; e++) begin
        wr_reg(8'hC8, 8'(e << 1));
        step(1);
        chk("R7 enable sweep", {7'b0, pme_n}, {7'b0, ~(g[0] && e != 0)});
      end
    end
    gen = 1'b0;
    step(1);
    chk("R7 global off", {7'b0, pme_n}, 8'h01);
    report();
  end
endmodule